// File: doc/BRIEF.md
# Carry-Derived Arithmetic Flag Register

This block holds the arithmetic status flags of a 36-bit word processor: overflow, carry out of the full word (carry 0), carry from the low 35 bits into the sign position (carry 1), and a PC-change flag. It also holds a byte-interrupt flag. The block contains the adder that produces the carries. Two operands and a carry-in enter the block, and the block returns the 36-bit sum, both carries and the overflow condition. A capture strobe from the add/subtract and increment/decrement classes moves the carries into the flags. Overflow is sticky: it is set when the carries disagree and is never cleared by a capture.

A flag-test jump presents a 4-bit mask. The block reports the jump as taken when any selected flag is set, and it clears every selected flag at the clock edge. The PC-change flag records each PC load or skip. The flags pack into the top six bits of a word for storage. A restore operation reloads the flags from the same positions of a word. During a restore, the PC-change flag is not set by the jump that accompanies the restore.

Top module: `arith_flag_reg`

## Requirements
- R1: `sum_out` equals (op_a + op_b + carry_in) mod 2^36. `cry0` is the carry out of bit 35. `cry1` is the carry out of the low 35 bits into bit 35.
- R2: `ovf_now` is high exactly when `cry0` and `cry1` differ.
- R3: On a clock edge with `arith_cap` high, flag_cry0 and flag_cry1 take the current `cry0` and `cry1`, and flag_ovf is set when `ovf_now` is high. A capture never clears flag_ovf.
- R4: `jump_taken` is high in the same cycle when `test_strobe` is high and at least one flag selected by `test_mask` is set. Mask bit 3 selects overflow, bit 2 carry 0, bit 1 carry 1 and bit 0 PC-change.
- R5: At the edge of a test cycle, every selected flag is cleared and unselected flags keep their value, whether or not the jump is taken.
- R6: `pc_event` or a taken test sets flag_pcchg at the edge. A clear of PC-change by the same test takes precedence, and so does a restore in the same cycle.
- R7: `restore_req` loads overflow, carry 0, carry 1, PC-change and byte-interrupt from word bits 35, 34, 33, 32 and 31 of `restore_word`. `user_req` is high in that cycle exactly when bit 30 of `restore_word` is set.
- R8: `store_word` holds overflow at bit 35, carry 0 at bit 34, carry 1 at bit 33, PC-change at bit 32, byte-interrupt at bit 31 and `user_mode` at bit 30. Bits 29..0 of `store_word` are zero.
- R9: A synchronous `rst` clears all five flags.
- R10: `byte_set` sets the byte-interrupt flag and `byte_clr` clears it. Clear wins over set, and a restore wins over both.
- R11: At most one of `arith_cap`, `test_strobe` and `restore_req` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_a | input | 36 | Adder operand A |
| op_b | input | 36 | Adder operand B |
| carry_in | input | 1 | Adder carry-in |
| arith_cap | input | 1 | Capture carries and overflow into flags |
| test_strobe | input | 1 | Flag test-and-clear operation |
| test_mask | input | 4 | Flag selection: bit 3 overflow, bit 2 carry 0, bit 1 carry 1, bit 0 PC-change |
| restore_req | input | 1 | Restore flags from `restore_word` |
| restore_word | input | 36 | Source word for restore |
| pc_event | input | 1 | PC loaded or skipped this cycle |
| byte_set | input | 1 | Set byte-interrupt flag |
| byte_clr | input | 1 | Clear byte-interrupt flag |
| user_mode | input | 1 | Current user mode, packed into the stored word |
| sum_out | output | 36 | Sum modulo 2^36 |
| cry0 | output | 1 | Carry out of the word |
| cry1 | output | 1 | Carry into the sign bit |
| ovf_now | output | 1 | Overflow condition of the current sum |
| jump_taken | output | 1 | Flag test found a selected flag set |
| user_req | output | 1 | Restore requests user mode |
| flag_ovf | output | 1 | Overflow flag |
| flag_cry0 | output | 1 | Carry 0 flag |
| flag_cry1 | output | 1 | Carry 1 flag |
| flag_pcchg | output | 1 | PC-change flag |
| flag_byte | output | 1 | Byte-interrupt flag |
| store_word | output | 36 | Packed flags for storage |

## Verification
The hardest state to reach is a taken test on the same edge as a clear of that test's own selection. In that case the PC-change flag is both set, because of the jump, and cleared, because it is selected. A second hard state is a sticky overflow that survives a later capture whose carries agree. The stimulus aims at both. It uses boundary operand pairs: largest positive plus one, two most-negative words, and all-ones plus one. These pairs force each carry combination. They are followed by tests with the PC-change bit in the mask while `pc_event` is also high. A long random phase then mixes exclusive operation choices with random events and random restore words.

// File: rtl/arith_flag_reg.sv
module arith_flag_reg #(
  parameter int W = 36
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         carry_in,
  input  logic         arith_cap,
  input  logic         test_strobe,
  input  logic [3:0]   test_mask,
  input  logic         restore_req,
  input  logic [W-1:0] restore_word,
  input  logic         pc_event,
  input  logic         byte_set,
  input  logic         byte_clr,
  input  logic         user_mode,
  output logic [W-1:0] sum_out,
  output logic         cry0,
  output logic         cry1,
  output logic         ovf_now,
  output logic         jump_taken,
  output logic         user_req,
  output logic         flag_ovf,
  output logic         flag_cry0,
  output logic         flag_cry1,
  output logic         flag_pcchg,
  output logic         flag_byte,
  output logic [W-1:0] store_word
);
  localparam int B_OVF  = W - 1;
  localparam int B_C0   = W - 2;
  localparam int B_C1   = W - 3;
  localparam int B_PC   = W - 4;
  localparam int B_BYTE = W - 5;
  localparam int B_USER = W - 6;

  logic [W:0] full;
  logic [3:0] flags, sel;

  assign full    = {1'b0, op_a} + {1'b0, op_b} + {{W{1'b0}}, carry_in};
  assign sum_out = full[W-1:0];
  assign cry0    = full[W];
  assign cry1    = full[W-1] ^ op_a[W-1] ^ op_b[W-1];
  assign ovf_now = cry0 ^ cry1;

  assign flags      = {flag_ovf, flag_cry0, flag_cry1, flag_pcchg};
  assign sel        = test_strobe ? test_mask : 4'b0000;
  assign jump_taken = |(sel & flags);
  assign user_req   = restore_req & restore_word[B_USER];

  assign store_word = {flag_ovf, flag_cry0, flag_cry1, flag_pcchg, flag_byte,
                       user_mode, {(W-6){1'b0}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_ovf   <= 1'b0;
      flag_cry0  <= 1'b0;
      flag_cry1  <= 1'b0;
      flag_pcchg <= 1'b0;
      flag_byte  <= 1'b0;
    end else if (restore_req) begin
      flag_ovf   <= restore_word[B_OVF];
      flag_cry0  <= restore_word[B_C0];
      flag_cry1  <= restore_word[B_C1];
      flag_pcchg <= restore_word[B_PC];
      flag_byte  <= restore_word[B_BYTE];
    end else begin
      if (sel[3])                    flag_ovf  <= 1'b0;
      else if (arith_cap && ovf_now) flag_ovf  <= 1'b1;
      if (sel[2])         flag_cry0 <= 1'b0;
      else if (arith_cap) flag_cry0 <= cry0;
      if (sel[1])         flag_cry1 <= 1'b0;
      else if (arith_cap) flag_cry1 <= cry1;
      if (sel[0])                        flag_pcchg <= 1'b0;
      else if (pc_event || jump_taken)   flag_pcchg <= 1'b1;
      if (byte_clr)      flag_byte <= 1'b0;
      else if (byte_set) flag_byte <= 1'b1;
    end
  end

  assert_one_op_R11: assert property (@(posedge clk) disable iff (rst)
    $countones({arith_cap, test_strobe, restore_req}) <= 1);

  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (rst)
    (op_a[W-1] != op_b[W-1]) |-> !ovf_now);

  assert_ovf_sticky_R3: assert property (@(posedge clk) disable iff (rst)
    (flag_ovf && !test_strobe && !restore_req) |=> flag_ovf);

  assert_cap_carry_R3: assert property (@(posedge clk) disable iff (rst)
    (arith_cap && !restore_req && !test_strobe) |=>
      (flag_cry0 == $past(cry0) && flag_cry1 == $past(cry1)));

  assert_test_clear_R5: assert property (@(posedge clk) disable iff (rst)
    (test_strobe && !restore_req && test_mask[3]) |=> !flag_ovf);

  assert_pc_set_R6: assert property (@(posedge clk) disable iff (rst)
    (pc_event && !restore_req && !(test_strobe && test_mask[0])) |=> flag_pcchg);

  assert_restore_R7: assert property (@(posedge clk) disable iff (rst)
    restore_req |=> (flag_pcchg == $past(restore_word[B_PC])));

  assert_reset_R9: assert property (@(posedge clk)
    rst |=> (!flag_ovf && !flag_cry0 && !flag_cry1 && !flag_pcchg && !flag_byte));
endmodule

// File: tb/sim_arith_flag_reg.sv
module sim_arith_flag_reg;
  logic        clk = 1'b0;
  logic        rst;
  logic [35:0] op_a, op_b, restore_word;
  logic        carry_in, arith_cap, test_strobe, restore_req, pc_event;
  logic        byte_set, byte_clr, user_mode;
  logic [3:0]  test_mask;
  logic [35:0] sum_out, store_word;
  logic        cry0, cry1, ovf_now, jump_taken, user_req;
  logic        flag_ovf, flag_cry0, flag_cry1, flag_pcchg, flag_byte;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  bit m_ovf, m_c0, m_c1, m_pc, m_byte;

  always #5 clk = ~clk;

  arith_flag_reg u0 (.*);

  task automatic cmp(input longint act, input longint exp, input string what);
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h at %0t", what, act, exp, $time);
    end
  endtask

  task automatic step(input bit r, input longint a, input longint b, input bit ci,
                      input bit cap, input bit tst, input bit [3:0] msk,
                      input bit rs, input longint w, input bit pce,
                      input bit bs, input bit bc, input bit um);
    longint full, low, e_sum;
    bit e_c0, e_c1, e_ovf, e_take;
    bit n_ovf, n_c0, n_c1, n_pc, n_byte;
    @(negedge clk);
    rst = r; op_a = a[35:0]; op_b = b[35:0]; carry_in = ci;
    arith_cap = cap; test_strobe = tst; test_mask = msk;
    restore_req = rs; restore_word = w[35:0]; pc_event = pce;
    byte_set = bs; byte_clr = bc; user_mode = um;
    #1;
    vectors++;
    full  = (a & 64'hF_FFFF_FFFF) + (b & 64'hF_FFFF_FFFF) + longint'(ci);
    low   = (a & 64'h7_FFFF_FFFF) + (b & 64'h7_FFFF_FFFF) + longint'(ci);
    e_sum = full % (64'd1 << 36);
    e_c0  = (full >= (64'd1 << 36));
    e_c1  = (low >= (64'd1 << 35));
    e_ovf = (e_c0 != e_c1);
    e_take = tst && ((msk[3] && m_ovf) || (msk[2] && m_c0) ||
                     (msk[1] && m_c1) || (msk[0] && m_pc));
    cmp(sum_out, e_sum, "R1 sum");
    cmp(cry0, e_c0, "R1 carry0");
    cmp(cry1, e_c1, "R1 carry1");
    cmp(ovf_now, e_ovf, "R2 overflow condition");
    cmp(jump_taken, e_take, "R4 jump taken");
    cmp(user_req, rs && w[30], "R7 user request");
    cmp(flag_ovf, m_ovf, "R3 flag ovf");
    cmp(flag_cry0, m_c0, "R3 flag carry0");
    cmp(flag_cry1, m_c1, "R5 flag carry1");
    cmp(flag_pcchg, m_pc, "R6 flag pc change");
    cmp(flag_byte, m_byte, "R10 flag byte");
    cmp(store_word, {m_ovf, m_c0, m_c1, m_pc, m_byte, um, 30'd0}, "R8 store word");
    if (r) begin
      n_ovf = 0; n_c0 = 0; n_c1 = 0; n_pc = 0; n_byte = 0;
    end else if (rs) begin
      n_ovf = w[35]; n_c0 = w[34]; n_c1 = w[33]; n_pc = w[32]; n_byte = w[31];
    end else begin
      n_ovf = (tst && msk[3]) ? 1'b0 : (cap && e_ovf) ? 1'b1 : m_ovf;
      n_c0  = (tst && msk[2]) ? 1'b0 : cap ? e_c0 : m_c0;
      n_c1  = (tst && msk[1]) ? 1'b0 : cap ? e_c1 : m_c1;
      n_pc  = (tst && msk[0]) ? 1'b0 : (pce || e_take) ? 1'b1 : m_pc;
      n_byte = bc ? 1'b0 : bs ? 1'b1 : m_byte;
    end
    @(posedge clk);
    m_ovf = n_ovf; m_c0 = n_c0; m_c1 = n_c1; m_pc = n_pc; m_byte = n_byte;
  endtask

  function automatic longint rnd36();
    return {28'd0, 4'($urandom), 32'($urandom)};
  endfunction

  initial begin
    #1000000;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    longint maxpos, minneg, ones;
    maxpos = 64'h7_FFFF_FFFF; minneg = 64'h8_0000_0000; ones = 64'hF_FFFF_FFFF;
    rst = 1; op_a = 0; op_b = 0; carry_in = 0; arith_cap = 0; test_strobe = 0;
    test_mask = 0; restore_req = 0; restore_word = 0; pc_event = 0;
    byte_set = 0; byte_clr = 0; user_mode = 0;
    m_ovf = 0; m_c0 = 0; m_c1 = 0; m_pc = 0; m_byte = 0;
    // R9 reset state: one step in reset fixes the model at zero
    @(posedge clk);
    step(1, 0, 0, 0, 0, 0, 4'h0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 4'h0, 0, 0, 0, 0, 0, 0);
    // R1 R2 R3: positive overflow, carry1 only
    step(0, maxpos, 1, 0, 1, 0, 4'h0, 0, 0, 0, 0, 0, 0);
    // R3 sticky overflow with agreeing carries (all ones plus one)
    step(0, ones, 1, 0, 1, 0, 4'h0, 0, 0, 0, 0, 0, 1);
    // two most negative: carry0 only
    step(0, minneg, minneg, 0, 1, 0, 4'h0, 0, 0, 0, 0, 0, 0);
    step(0, 5, 7, 1, 1, 0, 4'h0, 0, 0, 0, 0, 0, 0);
    // R4 R5 test overflow only, taken, pc set by jump
    step(0, 0, 0, 0, 0, 1, 4'b1000, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 1, 4'b1000, 0, 0, 0, 0, 0, 0);
    // R6 test selecting pc with pc_event: clear wins
    step(0, 0, 0, 0, 0, 1, 4'b0001, 0, 0, 1, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 4'h0, 0, 0, 1, 0, 0, 0);
    step(0, 0, 0, 0, 0, 1, 4'b1111, 0, 0, 0, 0, 0, 0);
    // R7 restore with pc_event: restore wins, user request
    step(0, 0, 0, 0, 0, 0, 4'h0, 1, 64'hA_4000_0000, 1, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 4'h0, 1, 64'hF_C000_0000, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0, 0, 4'h0, 0, 0, 0, 0, 0, 1);
    // R10 byte flag set and clear priority
    step(0, 0, 0, 0, 0, 0, 4'h0, 0, 0, 0, 1, 1, 0);
    step(0, 0, 0, 0, 0, 0, 4'h0, 0, 0, 0, 1, 0, 0);
    step(0, 0, 0, 0, 0, 0, 4'h0, 0, 0, 0, 1, 1, 0);
    // R9 mid-run reset after setting everything
    step(0, 0, 0, 0, 0, 0, 4'h0, 1, ones, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0, 0, 4'h0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 4'h0, 0, 0, 0, 0, 0, 0);
    // random phase with exclusive operations (R11)
    for (int i = 0; i < 3000; i++) begin
      int op;
      longint a, b;
      op = $urandom_range(0, 5);
      a = rnd36(); b = rnd36();
      if ($urandom_range(0, 3) == 0) a = ($urandom_range(0, 1) != 0) ? maxpos : minneg;
      if ($urandom_range(0, 3) == 0) b = ($urandom_range(0, 1) != 0) ? ones : minneg;
      step(($urandom_range(0, 199) == 0), a, b, 1'($urandom),
           op == 0 || op == 1, op == 2 || op == 3, 4'($urandom),
           op == 4, rnd36(), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule